// File: doc/BRIEF.md
# Accelerator Command Sequencer

This block is the central sequencer of a compute accelerator. A bus master writes 32-bit command words into an internal queue. Once started, the sequencer takes words from the queue in order and decodes them. Some instructions stream the words that follow them to a configuration sub-unit (an address generator or a DMA mover). Others load an internal 1024-entry command table, or replay a range of that table toward the compute array a set number of times while honouring a back-pressure stall. The remaining instructions pause for a fixed number of cycles, wait for a sub-unit to report completion, or return the sequencer to idle.

The host fills the queue while the sequencer is idle or running and pulses `go` to start decoding. Decoding ends at a halt instruction. Any words still queued after the halt wait for the next `go`.

Top module: `cmd_sequencer`

## Requirements
- R1: After reset, `idle` is 1 and `cfg_valid`, `seq_valid` and `fifo_full` are all 0.
- R2: A word offered on `push_data` with `push_en` high is stored when the queue holds fewer than 1024 words. `fifo_full` is 1 when the queue holds 1024 words, and a push made while full is dropped without disturbing the stored words. Words are decoded in the order they were pushed.
- R3: While idle, no instruction is decoded until `go` is pulsed high.
- R4: Opcode 1 (bits [31:29] = 1) is a block write with destination in [28:27] and count n in [15:0]. For destination 0 (address generator) or 2 (DMA mover), the next n queue words appear in order on `cfg_data`, each for one cycle with `cfg_valid` high and `cfg_dest` equal to the destination, and none of them is decoded as an instruction. `cfg_dest` is never odd while `cfg_valid` is high.
- R5: A block write with destination 1 stores its n words into the command table at consecutive addresses, starting at the base in [25:16] and wrapping from 1023 to 0. Destination 3 consumes its n words and discards them. A count of 0 consumes nothing further.
- R6: Opcode 2 replays the table with start address [28:19], end address [18:9] and pass count [8:0]. Entries start..end are emitted in ascending order, and the whole range is repeated for the given number of passes. A pass count of 0, or an end below the start, emits nothing.
- R7: An entry counts as delivered only in a cycle with `seq_valid` high and `seq_stall` low. While stalled, `seq_valid` stays high and `seq_data` holds the same entry.
- R8: Opcode 4 with N in [15:0] pauses decoding. Between two single-word block writes separated by this pause, the delivered configuration words are N+3 cycles apart, against 2 cycles with no pause between them.
- R9: Opcode 3 with unit index in [28:27] holds decoding until `unit_done` for that unit is 1. Done flags of other units have no effect.
- R10: Opcode 5 returns the sequencer to idle. Words queued behind it are not decoded until the next `go`.
- R11: Opcodes 0, 6 and 7 are consumed and have no effect.
- R12: `cfg_valid` and `seq_valid` are never high in the same cycle, and both are low while `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse; leaves idle |
| push_en | input | 1 | Queue write strobe |
| push_data | input | 32 | Command word to queue |
| fifo_full | output | 1 | Queue holds its full depth |
| unit_done | input | 4 | Per-unit completion flags used by probe |
| cfg_valid | output | 1 | Configuration word valid this cycle |
| cfg_dest | output | 2 | Destination of the configuration word |
| cfg_data | output | 32 | Configuration word |
| seq_valid | output | 1 | Table entry offered to the compute array |
| seq_data | output | 32 | Table entry being offered |
| seq_stall | input | 1 | Compute array cannot accept an entry |
| idle | output | 1 | Sequencer is idle |

## Verification
Directed programs come first. They cover the pause gap against back-to-back writes, a probe held by the wrong unit's flag and then released, a halt with words queued behind it, and table writes that wrap past address 1023. Replays of single entries, empty ranges and zero-pass replays are also directed. Random rounds then mix table loads, configuration writes to all four destinations, skipped opcodes and replays over random ranges under random stall. The delivered streams are compared with a bench model, which separates off-by-one range bounds, wrong pass counts and entries lost or duplicated across stalls. A forced long stall and a completely full queue with one extra push close the run.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    localparam int WORD_W    = 32;
    localparam int TBL_DEPTH = 1024;
    localparam int TBL_AW    = $clog2(TBL_DEPTH);
    localparam int CNT_W     = 16;
    localparam int PASS_W    = 9;
    localparam int UNIT_N    = 4;
    localparam int UNIT_W    = $clog2(UNIT_N);

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_BLKWR  = 3'd1,
        OP_REPLAY = 3'd2,
        OP_PROBE  = 3'd3,
        OP_PAUSE  = 3'd4,
        OP_HALT   = 3'd5
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_FORWARD,
        ST_REPLAY,
        ST_PROBE,
        ST_PAUSE
    } state_e;

    localparam logic [1:0] DEST_AG    = 2'd0;
    localparam logic [1:0] DEST_TABLE = 2'd1;
    localparam logic [1:0] DEST_MOVER = 2'd2;
    localparam logic [1:0] DEST_DROP  = 2'd3;

    typedef struct packed {
        state_e              state;
        logic [1:0]          dest;
        logic [CNT_W-1:0]    remain;
        logic [TBL_AW-1:0]   tbl_wa;
        logic [TBL_AW-1:0]   rp_start;
        logic [TBL_AW-1:0]   rp_end;
        logic [TBL_AW-1:0]   rp_ptr;
        logic [PASS_W-1:0]   pass_left;
        logic [UNIT_W-1:0]   unit;
        logic                cfg_valid;
        logic [1:0]          cfg_dest;
        logic [WORD_W-1:0]   cfg_data;
    } ctrl_t;

    function automatic logic [2:0] f_opcode(input logic [WORD_W-1:0] w);
        return w[31:29];
    endfunction
    function automatic logic [1:0] f_sel(input logic [WORD_W-1:0] w);
        return w[28:27];
    endfunction
    function automatic logic [TBL_AW-1:0] f_base(input logic [WORD_W-1:0] w);
        return w[25:16];
    endfunction
    function automatic logic [CNT_W-1:0] f_count(input logic [WORD_W-1:0] w);
        return w[15:0];
    endfunction
    function automatic logic [TBL_AW-1:0] f_start(input logic [WORD_W-1:0] w);
        return w[28:19];
    endfunction
    function automatic logic [TBL_AW-1:0] f_end(input logic [WORD_W-1:0] w);
        return w[18:9];
    endfunction
    function automatic logic [PASS_W-1:0] f_passes(input logic [WORD_W-1:0] w);
        return w[8:0];
    endfunction
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } qptr_t;

    logic [W-1:0] mem [DEPTH];
    qptr_t q_d, q_q;
    logic push_ok, pop_ok;

    assign full    = (q_q.cnt == (AW+1)'(DEPTH));
    assign empty   = (q_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[q_q.rp];

    always_comb begin
        q_d = q_q;
        if (push_ok) begin
            q_d.wp = (q_q.wp == AW'(DEPTH-1)) ? '0 : q_q.wp + 1'b1;
        end
        if (pop_ok) begin
            q_d.rp = (q_q.rp == AW'(DEPTH-1)) ? '0 : q_q.rp + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[q_q.wp] <= wdata;
        end
    end
endmodule

// File: rtl/seq_table.sv
module seq_table #(
    parameter int DEPTH = 1024,
    parameter int W     = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wa,
    input  logic [W-1:0]             wd,
    input  logic [$clog2(DEPTH)-1:0] ra,
    output logic [W-1:0]             rd
);
    logic [W-1:0] mem [DEPTH];

    assign rd = mem[ra];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
    import cmdseq_pkg::*;
#(
    parameter int QDEPTH = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              push_en,
    input  logic [WORD_W-1:0] push_data,
    output logic              fifo_full,
    input  logic [UNIT_N-1:0] unit_done,
    output logic              cfg_valid,
    output logic [1:0]        cfg_dest,
    output logic [WORD_W-1:0] cfg_data,
    output logic              seq_valid,
    output logic [WORD_W-1:0] seq_data,
    input  logic              seq_stall,
    output logic              idle
);
    ctrl_t ctrl_d, ctrl_q;

    logic              q_pop;
    logic              q_empty;
    logic [WORD_W-1:0] q_word;
    logic              tbl_we;
    logic [WORD_W-1:0] tbl_rd;

    cmdq_fifo #(.DEPTH(QDEPTH), .W(WORD_W)) queue_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_en),
        .wdata (push_data),
        .pop   (q_pop),
        .rdata (q_word),
        .empty (q_empty),
        .full  (fifo_full)
    );

    seq_table #(.DEPTH(TBL_DEPTH), .W(WORD_W)) table_i (
        .clk (clk),
        .we  (tbl_we),
        .wa  (ctrl_q.tbl_wa),
        .wd  (q_word),
        .ra  (ctrl_q.rp_ptr),
        .rd  (tbl_rd)
    );

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.cfg_valid = 1'b0;
        q_pop            = 1'b0;
        tbl_we           = 1'b0;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (go) begin
                    ctrl_d.state = ST_DECODE;
                end
            end

            ST_DECODE: begin
                if (!q_empty) begin
                    q_pop = 1'b1;
                    case (f_opcode(q_word))
                        OP_BLKWR: begin
                            ctrl_d.dest   = f_sel(q_word);
                            ctrl_d.remain = f_count(q_word);
                            ctrl_d.tbl_wa = f_base(q_word);
                            if (f_count(q_word) != '0) begin
                                ctrl_d.state = ST_FORWARD;
                            end
                        end
                        OP_REPLAY: begin
                            ctrl_d.rp_start  = f_start(q_word);
                            ctrl_d.rp_end    = f_end(q_word);
                            ctrl_d.rp_ptr    = f_start(q_word);
                            ctrl_d.pass_left = f_passes(q_word) - 1'b1;
                            if (f_passes(q_word) != '0 &&
                                f_end(q_word) >= f_start(q_word)) begin
                                ctrl_d.state = ST_REPLAY;
                            end
                        end
                        OP_PROBE: begin
                            ctrl_d.unit  = f_sel(q_word);
                            ctrl_d.state = ST_PROBE;
                        end
                        OP_PAUSE: begin
                            ctrl_d.remain = f_count(q_word);
                            if (f_count(q_word) != '0) begin
                                ctrl_d.state = ST_PAUSE;
                            end
                        end
                        OP_HALT: begin
                            ctrl_d.state = ST_IDLE;
                        end
                        default: begin
                            ctrl_d.state = ST_DECODE;
                        end
                    endcase
                end
            end

            ST_FORWARD: begin
                if (!q_empty) begin
                    q_pop = 1'b1;
                    case (ctrl_q.dest)
                        DEST_TABLE: begin
                            tbl_we        = 1'b1;
                            ctrl_d.tbl_wa = ctrl_q.tbl_wa + 1'b1;
                        end
                        DEST_AG, DEST_MOVER: begin
                            ctrl_d.cfg_valid = 1'b1;
                            ctrl_d.cfg_dest  = ctrl_q.dest;
                            ctrl_d.cfg_data  = q_word;
                        end
                        default: begin
                            ctrl_d.cfg_valid = 1'b0;
                        end
                    endcase
                    ctrl_d.remain = ctrl_q.remain - 1'b1;
                    if (ctrl_q.remain == CNT_W'(1)) begin
                        ctrl_d.state = ST_DECODE;
                    end
                end
            end

            ST_REPLAY: begin
                if (!seq_stall) begin
                    if (ctrl_q.rp_ptr == ctrl_q.rp_end) begin
                        if (ctrl_q.pass_left == '0) begin
                            ctrl_d.state = ST_DECODE;
                        end else begin
                            ctrl_d.rp_ptr    = ctrl_q.rp_start;
                            ctrl_d.pass_left = ctrl_q.pass_left - 1'b1;
                        end
                    end else begin
                        ctrl_d.rp_ptr = ctrl_q.rp_ptr + 1'b1;
                    end
                end
            end

            ST_PROBE: begin
                if (unit_done[ctrl_q.unit]) begin
                    ctrl_d.state = ST_DECODE;
                end
            end

            ST_PAUSE: begin
                ctrl_d.remain = ctrl_q.remain - 1'b1;
                if (ctrl_q.remain == CNT_W'(1)) begin
                    ctrl_d.state = ST_DECODE;
                end
            end

            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            ctrl_q.state <= ST_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign idle      = (ctrl_q.state == ST_IDLE);
    assign cfg_valid = ctrl_q.cfg_valid;
    assign cfg_dest  = ctrl_q.cfg_dest;
    assign cfg_data  = ctrl_q.cfg_data;
    assign seq_valid = (ctrl_q.state == ST_REPLAY);
    assign seq_data  = tbl_rd;
endmodule

// File: rtl/cmd_sequencer_chk.sv
module cmd_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        go,
    input logic        idle,
    input logic        cfg_valid,
    input logic [1:0]  cfg_dest,
    input logic        seq_valid,
    input logic [31:0] seq_data,
    input logic        seq_stall
);
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && seq_valid));

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!cfg_valid && !seq_valid));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_valid && seq_stall) |=> (seq_valid && $stable(seq_data)));

    a_r4_dest_even: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !cfg_dest[0]);

    a_r3_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !go) |=> idle);
endmodule

bind cmd_sequencer cmd_sequencer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .idle      (idle),
    .cfg_valid (cfg_valid),
    .cfg_dest  (cfg_dest),
    .seq_valid (seq_valid),
    .seq_data  (seq_data),
    .seq_stall (seq_stall)
);

// File: tb/cmd_sequencer_tb_top.sv
module cmd_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        push_en = 1'b0;
    logic [31:0] push_data = '0;
    logic        fifo_full;
    logic [3:0]  unit_done = 4'hF;
    logic        cfg_valid;
    logic [1:0]  cfg_dest;
    logic [31:0] cfg_data;
    logic        seq_valid;
    logic [31:0] seq_data;
    logic        seq_stall = 1'b0;
    logic        idle;

    always #10 clk = ~clk;

    cmd_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .push_en(push_en), .push_data(push_data),
        .fifo_full(fifo_full), .unit_done(unit_done), .cfg_valid(cfg_valid),
        .cfg_dest(cfg_dest), .cfg_data(cfg_data), .seq_valid(seq_valid),
        .seq_data(seq_data), .seq_stall(seq_stall), .idle(idle)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int stall_mode = 0;

    logic [33:0] exp_cfg[$], got_cfg[$];
    logic [31:0] exp_seq[$], got_seq[$];
    int          cfg_t[$];
    logic [31:0] tbl_m [1024];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: drives stall, then samples the settled outputs
    always @(negedge clk) begin
        seq_stall = (stall_mode == 2) ? 1'b1 :
                    (stall_mode == 1) ? (($urandom % 3) == 0) : 1'b0;
        #1;
        if (rst_n && seq_valid && !seq_stall) got_seq.push_back(seq_data);
        if (rst_n && cfg_valid) begin
            got_cfg.push_back({cfg_dest, cfg_data});
            cfg_t.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_blk(input int dest, input int base, input int n);
        return {3'd1, 2'(dest), 1'b0, 10'(base), 16'(n)};
    endfunction
    function automatic logic [31:0] enc_rep(input int s, input int e, input int p);
        return {3'd2, 10'(s), 10'(e), 9'(p)};
    endfunction
    function automatic logic [31:0] enc_probe(input int u);
        return {3'd3, 2'(u), 27'd0};
    endfunction
    function automatic logic [31:0] enc_pause(input int n);
        return {3'd4, 13'd0, 16'(n)};
    endfunction
    localparam logic [31:0] HALT = 32'hA000_0000;

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        push_en   = 1'b1;
        push_data = w;
        @(negedge clk);
        push_en   = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!idle) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic m_blk(input int dest, input int base, input int n);
        push(enc_blk(dest, base, n));
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = $urandom;
            push(w);
            if (dest == 0 || dest == 2) exp_cfg.push_back({2'(dest), w});
            if (dest == 1) tbl_m[(base + i) % 1024] = w;
        end
    endtask

    task automatic m_rep(input int s, input int e, input int p);
        push(enc_rep(s, e, p));
        if (e >= s)
            for (int k = 0; k < p; k++)
                for (int a = s; a <= e; a++) exp_seq.push_back(tbl_m[a]);
    endtask

    task automatic compare(input string req);
        chk(got_cfg.size() == exp_cfg.size(), {req, " cfg count"}, 64'(got_cfg.size()), 64'(exp_cfg.size()));
        for (int i = 0; i < got_cfg.size() && i < exp_cfg.size(); i++)
            chk(got_cfg[i] === exp_cfg[i], {req, " cfg word"}, 64'(got_cfg[i]), 64'(exp_cfg[i]));
        chk(got_seq.size() == exp_seq.size(), {req, " seq count"}, 64'(got_seq.size()), 64'(exp_seq.size()));
        for (int i = 0; i < got_seq.size() && i < exp_seq.size(); i++)
            chk(got_seq[i] === exp_seq[i], {req, " seq entry"}, 64'(got_seq[i]), 64'(exp_seq[i]));
        exp_cfg.delete(); got_cfg.delete(); exp_seq.delete(); got_seq.delete(); cfg_t.delete();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) tbl_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(idle === 1'b1, "R1 idle", 64'(idle), 1);
        chk(cfg_valid === 1'b0 && seq_valid === 1'b0, "R1 valids", 64'({cfg_valid, seq_valid}), 0);
        chk(fifo_full === 1'b0, "R1 full", 64'(fifo_full), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: no decode before go; R4 forwarding to address generator
        m_blk(0, 0, 2);
        push(HALT);
        repeat (20) @(negedge clk);
        chk(got_cfg.size() == 0 && idle, "R3 no decode while idle", 64'(got_cfg.size()), 0);
        kick(); wait_idle();
        compare("R4");

        // R8 pause gaps
        push(enc_blk(0, 0, 1)); push(32'h1111_0001);
        push(enc_pause(7));
        push(enc_blk(0, 0, 1)); push(32'h1111_0002);
        push(enc_blk(2, 0, 1)); push(32'h1111_0003);
        push(enc_pause(0));
        push(enc_blk(0, 0, 1)); push(32'h1111_0004);
        push(HALT);
        kick(); wait_idle();
        chk(cfg_t.size() == 4, "R8 word count", 64'(cfg_t.size()), 4);
        if (cfg_t.size() == 4) begin
            chk(cfg_t[1] - cfg_t[0] == 10, "R8 gap N=7", 64'(cfg_t[1] - cfg_t[0]), 10);
            chk(cfg_t[2] - cfg_t[1] == 2, "R8 gap none", 64'(cfg_t[2] - cfg_t[1]), 2);
            chk(cfg_t[3] - cfg_t[2] == 3, "R8 gap N=0", 64'(cfg_t[3] - cfg_t[2]), 3);
        end
        exp_cfg.push_back({2'd0, 32'h1111_0001}); exp_cfg.push_back({2'd0, 32'h1111_0002});
        exp_cfg.push_back({2'd2, 32'h1111_0003}); exp_cfg.push_back({2'd0, 32'h1111_0004});
        compare("R8");

        // R9 probe
        unit_done = 4'b0000;
        push(enc_probe(2));
        m_blk(0, 0, 1);
        push(HALT);
        kick();
        repeat (40) @(negedge clk);
        chk(got_cfg.size() == 0 && !idle, "R9 held by probe", 64'(got_cfg.size()), 0);
        unit_done = 4'b0010;
        repeat (15) @(negedge clk);
        chk(got_cfg.size() == 0, "R9 other unit ignored", 64'(got_cfg.size()), 0);
        unit_done = 4'b0100;
        wait_idle();
        unit_done = 4'hF;
        compare("R9");

        // R10 halt leaves later words queued
        m_blk(0, 0, 1);
        push(HALT);
        push(enc_blk(2, 0, 1)); push(32'h2222_0002);
        push(HALT);
        kick(); wait_idle();
        repeat (20) @(negedge clk);
        chk(got_cfg.size() == 1 && idle, "R10 stop at halt", 64'(got_cfg.size()), 1);
        exp_cfg.push_back({2'd2, 32'h2222_0002});
        kick(); wait_idle();
        compare("R10");

        // R5/R6/R11 wrap, corner ranges, dropped destination, skipped opcodes
        stall_mode = 1;
        m_blk(1, 1022, 4);
        m_rep(1022, 1023, 2);
        m_rep(0, 1, 1);
        m_rep(5, 3, 3);
        m_rep(0, 0, 0);
        m_rep(1023, 1023, 3);
        m_blk(3, 0, 2);
        m_blk(1, 10, 0);
        push(32'h0000_1234); push(32'hC000_0007); push(32'hE000_0001);
        m_blk(2, 0, 1);
        push(HALT);
        kick(); wait_idle();
        compare("R6");

        // R7 long stall holds first entry
        stall_mode = 2;
        m_blk(1, 200, 3);
        m_rep(200, 202, 2);
        push(HALT);
        kick();
        repeat (40) @(negedge clk);
        chk(got_seq.size() == 0, "R7 nothing delivered while stalled", 64'(got_seq.size()), 0);
        chk(seq_valid === 1'b1 && seq_data === tbl_m[200], "R7 entry held", 64'(seq_data), 64'(tbl_m[200]));
        stall_mode = 1;
        wait_idle();
        compare("R7");

        // random rounds
        for (int r = 0; r < 6; r++) begin
            int base, n, s, e;
            base = $urandom % 900;
            n = 8 + $urandom % 16;
            m_blk(1, base, n);
            m_blk(0, 0, 1 + $urandom % 4);
            push(32'h0000_0000);
            push(32'hC000_0000);
            m_blk(2, 0, 1 + $urandom % 3);
            s = base + $urandom % n;
            e = s + $urandom % (base + n - s);
            m_rep(s, e, 1 + $urandom % 3);
            push(enc_pause($urandom % 6));
            m_blk(3, 0, 2);
            m_rep(base, base + n - 1, 1);
            push(HALT);
            kick(); wait_idle();
            compare("R5 R6 R11 random");
        end
        stall_mode = 0;

        // R2 full queue, extra push dropped
        push(enc_blk(0, 0, 1));
        push(32'hAAAA_AAAA);
        for (int i = 2; i < 1023; i++) push(32'h0);
        push(HALT);
        chk(fifo_full === 1'b1, "R2 full flag", 64'(fifo_full), 1);
        push(32'h0);
        exp_cfg.push_back({2'd0, 32'hAAAA_AAAA});
        kick(); wait_idle();
        chk(fifo_full === 1'b0, "R2 drained", 64'(fifo_full), 0);
        compare("R2");

        summary();
    end
endmodule